// File: doc/BRIEF.md
# Open-Row DRAM Bank Access Sequencer

This block drives one DRAM bank of 4096 rows by 4096 columns. It takes read requests with a 24-bit address and remembers which row is held in the bank's row buffer. Each request is classified against that row. A request to the latched row is a hit. A request made when no row is latched goes to an empty buffer. A request to any other row is a conflict.

From that class the block runs the phases the access needs. A conflict first writes back the open row. An empty or conflicting access then activates the new row. Every access goes through a column phase and ends with an 8-bit serial transfer. The row stays latched after each access, so later requests to the same row take the short path.

The bank contents are a behavioural model: each byte is computed from its row and column, so the default size needs no storage. Phase lengths come from three total-latency parameters, with one cycle standing for one nanosecond.

Top module: `dram_openrow_seq`

## Requirements
- R1: The row is `req_addr[23:12]` and the column is `req_addr[11:0]`. The byte returned for (row, col) is `((row[7:0] + col[7:0]) mod 256) XOR {col[11:8], row[11:8]}`.
- R2: `req_ready` is high only when the sequencer is idle. A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. `req_valid` has no effect while busy.
- R3: At the accept edge, `status` takes the class of the request and holds it until the next accept. The codes are 0 = hit, 1 = empty, 2 = conflict.
- R4: A hit lasts HIT_LAT (default 20) cycles. Counting the cycle after the accept edge as cycle 1, `done` is high in cycle HIT_LAT and `col_strobe` is high for HIT_LAT-8 cycles.
- R5: An empty access lasts EMPTY_LAT (default 40) cycles. `row_strobe` is high for EMPTY_LAT-HIT_LAT cycles, then `col_strobe` follows.
- R6: A conflict lasts CONFLICT_LAT (default 60) cycles, in this order:
  - `wb_strobe` for CONFLICT_LAT-EMPTY_LAT cycles;
  - `row_strobe` for EMPTY_LAT-HIT_LAT cycles;
  - `col_strobe` for HIT_LAT-8 cycles.
- R7: The byte leaves on `data_bit` LSB first during the last 8 cycles of the access, with `data_valid` high. `done` is high only with the last bit, and `req_ready` returns in the next cycle.
- R8: Open-page policy: the row of each accepted request stays latched after the access completes. Only reset empties the buffer.
- R9: While reset is high, and in the cycle after it is released, the outputs are as follows:
  - `req_ready` is 1;
  - `data_valid`, `done` and all three strobes are 0;
  - `status` is 1 (empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_addr | input | 24 | Row (upper 12) and column (lower 12) |
| status | output | 2 | Class of the last accepted request |
| wb_strobe | output | 1 | Writeback/precharge phase active |
| row_strobe | output | 1 | Row activate phase active |
| col_strobe | output | 1 | Column select phase active |
| data_bit | output | 1 | Serial data bit |
| data_valid | output | 1 | `data_bit` carries data |
| done | output | 1 | Last bit of the access |

## Verification
All timing is counted from the accept edge, taken as cycle 0.
- `status` is due in cycle 1.
- Bit i of the byte is due in cycle LAT-7+i, and `done` is due in cycle LAT.
- `req_ready` is low through cycle LAT and high again in cycle LAT+1.

The bench samples at the falling edge of each numbered cycle. It counts strobe cycles over the whole access and checks every sample against the cycle number where its value is due. The tests that request the same row again after an access, after a reset or after an ignored request show which row is latched through `status` alone.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    parameter int ROW_BITS  = 12;
    parameter int COL_BITS  = 12;
    parameter int ADDR_BITS = ROW_BITS + COL_BITS;
    parameter int BYTE_BITS = 8;

    typedef logic [ROW_BITS-1:0]  row_t;
    typedef logic [COL_BITS-1:0]  col_t;
    typedef logic [BYTE_BITS-1:0] byte_t;

    typedef struct packed {
        row_t row;
        col_t col;
    } bank_addr_t;

    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_EMPTY    = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WB,
        PH_ACT,
        PH_COL,
        PH_XFER
    } phase_e;

    function automatic byte_t cell_byte(row_t r, col_t c);
        byte_t s;
        s = r[7:0] + c[7:0];
        return s ^ {c[11:8], r[11:8]};
    endfunction

    function automatic acc_kind_e classify(logic open_v, row_t open_r, row_t r);
        if (!open_v)     return ACC_EMPTY;
        if (open_r == r) return ACC_HIT;
        return ACC_CONFLICT;
    endfunction

endpackage

// File: rtl/bank_tracker.sv
module bank_tracker
    import dseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  row_t      req_row,
    output logic      open_valid,
    output row_t      open_row,
    output acc_kind_e kind
);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_valid <= 1'b0;
            open_row   <= '0;
        end else if (accept) begin
            open_valid <= 1'b1;
            open_row   <= req_row;
        end
    end

    always_comb kind = classify(open_valid, open_row, req_row);

    assert_row_open_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> (open_valid && open_row == $past(req_row)));

    assert_row_kept_R8: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(open_row) && $stable(open_valid));

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
    import dseq_pkg::*;
#(
    parameter int HIT_LAT      = 20,
    parameter int EMPTY_LAT    = 40,
    parameter int CONFLICT_LAT = 60
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  acc_kind_e kind,
    output logic      ready_o,
    output logic      wb_o,
    output logic      act_o,
    output logic      col_o,
    output logic      xfer_o,
    output logic      last_o,
    output logic      load_o
);

    localparam int WB_LEN  = CONFLICT_LAT - EMPTY_LAT;
    localparam int ACT_LEN = EMPTY_LAT - HIT_LAT;
    localparam int COL_LEN = HIT_LAT - BYTE_BITS;
    localparam int CW      = $clog2(CONFLICT_LAT + 1);

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [CW-1:0] span(phase_e p);
        case (p)
            PH_WB:   return CW'(WB_LEN - 1);
            PH_ACT:  return CW'(ACT_LEN - 1);
            PH_COL:  return CW'(COL_LEN - 1);
            PH_XFER: return CW'(BYTE_BITS - 1);
            default: return '0;
        endcase
    endfunction

    function automatic phase_e follow(phase_e p);
        case (p)
            PH_WB:   return PH_ACT;
            PH_ACT:  return PH_COL;
            PH_COL:  return PH_XFER;
            default: return PH_IDLE;
        endcase
    endfunction

    function automatic phase_e entry(acc_kind_e k);
        case (k)
            ACC_CONFLICT: return PH_WB;
            ACC_EMPTY:    return PH_ACT;
            default:      return PH_COL;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else if (ph_q == PH_IDLE) begin
            if (accept) begin
                ph_q  <= entry(kind);
                cnt_q <= span(entry(kind));
            end
        end else if (cnt_q == '0) begin
            ph_q  <= follow(ph_q);
            cnt_q <= span(follow(ph_q));
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        ready_o = (ph_q == PH_IDLE);
        wb_o    = (ph_q == PH_WB);
        act_o   = (ph_q == PH_ACT);
        col_o   = (ph_q == PH_COL);
        xfer_o  = (ph_q == PH_XFER);
        last_o  = xfer_o && (cnt_q == '0);
        load_o  = col_o && (cnt_q == '0);
    end

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready_o);

    assert_done_frees_R7: assert property (@(posedge clk) disable iff (rst)
        last_o |=> ready_o);

    assert_xfer_contig_R7: assert property (@(posedge clk) disable iff (rst)
        (xfer_o && !last_o) |=> xfer_o);

    assert_act_entry_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(act_o) |-> ($past(wb_o) || $past(ready_o)));

    assert_col_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(col_o) |-> ($past(act_o) || $past(ready_o)));

endmodule

// File: rtl/byte_serializer.sv
module byte_serializer
    import dseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  shift,
    input  byte_t byte_in,
    output logic  bit_o
);

    byte_t sr_q;

    always_ff @(posedge clk) begin
        if (rst)        sr_q <= '0;
        else if (load)  sr_q <= byte_in;
        else if (shift) sr_q <= {1'b0, sr_q[BYTE_BITS-1:1]};
    end

    assign bit_o = sr_q[0];

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> (sr_q == $past(byte_in)));

endmodule

// File: rtl/dram_openrow_seq.sv
module dram_openrow_seq
    import dseq_pkg::*;
#(
    parameter int HIT_LAT      = 20,
    parameter int EMPTY_LAT    = 40,
    parameter int CONFLICT_LAT = 60
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_BITS-1:0] req_addr,
    output logic [1:0]           status,
    output logic                 wb_strobe,
    output logic                 row_strobe,
    output logic                 col_strobe,
    output logic                 data_bit,
    output logic                 data_valid,
    output logic                 done
);

    bank_addr_t a_in;
    logic       accept;
    logic       open_valid;
    row_t       open_row;
    acc_kind_e  kind;
    acc_kind_e  status_q;
    col_t       col_q;
    logic       load;

    assign a_in   = bank_addr_t'(req_addr);
    assign accept = req_valid && req_ready;

    bank_tracker u_track (
        .clk(clk), .rst(rst), .accept(accept), .req_row(a_in.row),
        .open_valid(open_valid), .open_row(open_row), .kind(kind)
    );

    phase_sequencer #(
        .HIT_LAT(HIT_LAT), .EMPTY_LAT(EMPTY_LAT), .CONFLICT_LAT(CONFLICT_LAT)
    ) u_seq (
        .clk(clk), .rst(rst), .accept(accept), .kind(kind),
        .ready_o(req_ready), .wb_o(wb_strobe), .act_o(row_strobe),
        .col_o(col_strobe), .xfer_o(data_valid), .last_o(done), .load_o(load)
    );

    byte_serializer u_ser (
        .clk(clk), .rst(rst), .load(load), .shift(data_valid),
        .byte_in(cell_byte(open_row, col_q)), .bit_o(data_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= ACC_EMPTY;
            col_q    <= '0;
        end else if (accept) begin
            status_q <= kind;
            col_q    <= a_in.col;
        end
    end

    assign status = status_q;

    assert_status_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(status));

    assert_hit_needs_open_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == ACC_HIT) |-> open_valid);

    assert_done_with_data_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> data_valid);

endmodule

// File: tb/dram_openrow_seq_test.sv
`timescale 1ns/1ps
module dram_openrow_seq_test;

    localparam int HL = 20, EL = 40, CL = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [1:0]  status;
    logic        wb_strobe, row_strobe, col_strobe, data_bit, data_valid, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dram_openrow_seq #(.HIT_LAT(HL), .EMPTY_LAT(EL), .CONFLICT_LAT(CL)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .status(status), .wb_strobe(wb_strobe),
        .row_strobe(row_strobe), .col_strobe(col_strobe), .data_bit(data_bit),
        .data_valid(data_valid), .done(done)
    );

    // address (24 bits) and expected class (0 hit, 1 empty, 2 conflict)
    localparam logic [25:0] VEC [8] = '{
        {24'h123045, 2'd1}, {24'h1237FF, 2'd0}, {24'h123FFF, 2'd0},
        {24'hABC010, 2'd2}, {24'hABC010, 2'd0}, {24'h000000, 2'd2},
        {24'hFFFFFF, 2'd2}, {24'hFFF000, 2'd0}
    };

    function automatic logic [7:0] ref_byte(logic [23:0] a);
        logic [7:0] s;
        s = a[19:12] + a[7:0];
        return s ^ {a[11:8], a[23:20]};
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_idle_state(string tag);
        chk({tag, " ready"}, req_ready, 1);
        chk({tag, " data_valid"}, data_valid, 0);
        chk({tag, " done"}, done, 0);
        chk({tag, " strobes"}, {wb_strobe, row_strobe, col_strobe}, 0);
    endtask

    // One access; hold_busy keeps req_valid high with alt during the busy cycles.
    task automatic run_req(logic [23:0] a, int kind, bit hold_busy, logic [23:0] alt);
        int lat, nwb, nact, ncol;
        logic [7:0] b;
        lat = (kind == 0) ? HL : (kind == 1) ? EL : CL;
        b = ref_byte(a);
        nwb = 0; nact = 0; ncol = 0;
        @(negedge clk);
        chk("R2 ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        for (int j = 1; j <= lat + 1; j++) begin
            @(negedge clk);
            if (hold_busy && j < lat) begin
                req_valid = 1'b1;
                req_addr  = alt;
            end else begin
                req_valid = 1'b0;
            end
            if (j == 1) chk("R3 status class", status, kind);
            if (j <= lat) begin
                nwb  += wb_strobe;
                nact += row_strobe;
                ncol += col_strobe;
                chk("R2 ready low while busy", req_ready, 0);
                if (j > lat - 8) begin
                    chk("R7 data_valid", data_valid, 1);
                    chk("R1 R7 serial bit", data_bit, b[j - (lat - 7)]);
                end else begin
                    chk("R7 data_valid early", data_valid, 0);
                end
                chk("R7 done timing", done, (j == lat) ? 1 : 0);
            end else begin
                chk("R7 ready after done", req_ready, 1);
                chk("R3 status held", status, kind);
            end
        end
        chk("R6 wb cycles", nwb, (kind == 2) ? CL - EL : 0);
        chk("R5 activate cycles", nact, (kind == 0) ? 0 : EL - HL);
        chk("R4 column cycles", ncol, HL - 8);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle_state("R9 in reset");
        chk("R9 status in reset", status, 1);
        rst = 1'b0;
        @(negedge clk);
        chk_idle_state("R9 after reset");
        chk("R9 status after reset", status, 1);

        // R2: no valid, nothing happens
        repeat (5) begin
            @(negedge clk);
            chk_idle_state("R2 idle without valid");
        end

        // R4 R5 R6 R8: vector table
        for (int i = 0; i < 8; i++)
            run_req(VEC[i][25:2], int'(VEC[i][1:0]), 1'b0, 24'h0);

        // R2: valid held during busy with another row is ignored
        run_req(24'h5A5001, 2, 1'b1, 24'h777777);
        repeat (3) begin
            @(negedge clk);
            chk_idle_state("R2 no accept after ignored request");
        end
        run_req(24'h5A5100, 0, 1'b0, 24'h0);   // R8: row 5A5 still open

        // R9 R8: reset in the middle of an access empties the buffer
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 24'h246800;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (9) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk_idle_state("R9 reset mid access");
        chk("R9 status reset mid access", status, 1);
        rst = 1'b0;
        run_req(24'h246800, 1, 1'b0, 24'h0);
        run_req(24'h246FFF, 0, 1'b0, 24'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule